// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces a Repeated Start condition on an I2C bus as a bus master. It controls the two open-drain lines through pull-low enables, reads both lines back through two-flop synchronizers, and times every phase with a reloadable baud down-counter. Software raises a request strobe. If nothing else is pending, the block takes over the bus. It first pulls SCL low with SDA released, then releases SCL, then pulls SDA low while SCL is high. It finishes with SDA still held low, ready for the first bit of the next transfer.

Each phase waits for the synchronized line to reach the expected level before it reloads the counter. A slave or another master that stretches SCL therefore lengthens the sequence instead of corrupting it. During the sequence the block checks for lost arbitration. A transmit-buffer write or an event-control write made while the sequence runs is refused, so events cannot be queued. Status flags report a detected start condition, completion, write collisions and bus collisions.

Top module: `i2c_rstart_gen`

## Requirements
- R1: A request strobe is accepted only when the sequencer is idle and the event-control bits `ctl_bits` are all zero. Otherwise the strobe changes no output.
- R2: On acceptance, `rs_req` goes to 1 and `scl_oe` goes to 1, where 1 means the line is pulled low. SDA is released. The counter is loaded only after SCL is seen low at the synchronizer output. SCL is held low for the synchronizer latency plus one cycle, plus `brg_reload`+1 cycles.
- R3: When that period ends, SCL is released only if synchronized SDA is high. While SDA is held low by another agent, `scl_oe` stays 1.
- R4: After SCL is released, the block waits for synchronized SCL to be high, then reloads the counter and keeps both lines released for `brg_reload`+1 cycles. An external device holding SCL low extends the released phase cycle for cycle.
- R5: SDA is then pulled low for `brg_reload`+1 cycles while SCL stays released. After that, `rs_req` clears by itself and `sda_oe` stays 1.
- R6: `start_seen` sets when synchronized SDA falls while synchronized SCL was and is high. `irq_flag` sets only when the final SDA-low period ends, so it follows `start_seen`.
- R7: A `tx_wr` while `rs_req` is 1 sets `wcol` and leaves `tx_buf` unchanged. A `tx_wr` while idle loads `tx_data` into `tx_buf`.
- R8: A `ctl_wr` while `rs_req` is 1 leaves `ctl_bits` unchanged. A `ctl_wr` while idle loads `ctl_data`.
- R9: A bus collision sets `bcol` in two cases: SDA is seen low when SCL is seen rising after release, or SCL is seen low during the both-released phase. On a collision both enables drop to 0, `rs_req` clears, the block returns to idle and `irq_flag` is not set.
- R10: `flags_clr` clears `start_seen`, `irq_flag`, `wcol` and `bcol`. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs_req_set | input | 1 | Software strobe requesting a Repeated Start |
| brg_reload | input | 7 | Baud counter reload value; period is reload+1 cycles |
| tx_wr | input | 1 | Transmit-buffer write strobe |
| tx_data | input | 8 | Transmit-buffer write data |
| ctl_wr | input | 1 | Write strobe for the other event-control bits |
| ctl_data | input | 4 | Event-control write data |
| flags_clr | input | 1 | Clears all sticky status flags |
| scl_in | input | 1 | SCL line level as seen on the bus |
| sda_in | input | 1 | SDA line level as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rs_req | output | 1 | Request bit; clears itself when the sequence ends |
| start_seen | output | 1 | Start condition detected on the lines |
| irq_flag | output | 1 | Sequence completed |
| wcol | output | 1 | Write collision on the transmit buffer |
| bcol | output | 1 | Bus collision during the sequence |
| tx_buf | output | 8 | Transmit-buffer contents |
| ctl_bits | output | 4 | Event-control bits |

## Verification
The bench models a pulled-up open-drain bus. It runs the sequence with no interference at two reload values, which separates a fixed delay from one that scales with the reload value. A second agent stretching SCL shows that the released phase grows by exactly the stretch. A second agent holding SDA low shows that SCL stays held instead of being released early. Injected low pulses, one at the SCL rise and one during the both-high phase, exercise the two collision causes separately. Buffer and control writes made mid-sequence and while idle tell refusal apart from normal loading.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PULL    = 3'd1,
    ST_SDA_HI  = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_BOTH_HI = 3'd4,
    ST_SDA_LO  = 3'd5
  } rs_state_e;

  // Length of one timing unit, in clock cycles, for a given reload value.
  function automatic int unsigned baud_cycles(input int unsigned reload);
    return reload + 1;
  endfunction

  // Start condition: data falls while clock is high on two consecutive samples.
  function automatic logic is_start(input logic scl_p, input logic scl_n,
                                    input logic sda_p, input logic sda_n);
    return scl_p & scl_n & sda_p & ~sda_n;
  endfunction

endpackage

// File: rtl/rs_line_sync.sv
module rs_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int CW = W * STAGES;

  logic [CW-1:0] chain_q;
  logic [W-1:0]  prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= '1;
    end else begin
      chain_q <= {chain_q[CW-W-1:0], async_i};
      prev_q  <= chain_q[CW-1 -: W];
    end
  end

  assign sync_o = chain_q[CW-1 -: W];
  assign prev_o = prev_q;
endmodule

// File: rtl/rs_baud_ctr.sv
module rs_baud_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= reload;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4: counter holds while the sequencer waits on a line level
  a_r4_hold_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic evt_pending,
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_prev,
  input  logic sda_prev,
  input  logic brg_expired,
  output logic brg_load,
  output logic brg_run,
  output logic scl_oe,
  output logic sda_oe,
  output logic rs_req,
  output logic done_evt,
  output logic bcol_evt,
  output logic start_evt
);
  rs_state_e st_q, st_d;
  logic      hold_q, hold_d;

  always_comb begin
    st_d     = st_q;
    hold_d   = hold_q;
    brg_load = 1'b0;
    brg_run  = 1'b0;
    done_evt = 1'b0;
    bcol_evt = 1'b0;
    case (st_q)
      ST_IDLE: if (req_set && !evt_pending) begin
        st_d   = ST_PULL;
        hold_d = 1'b0;
      end
      ST_PULL: if (!scl_s) begin
        st_d     = ST_SDA_HI;
        brg_load = 1'b1;
      end
      ST_SDA_HI: begin
        brg_run = 1'b1;
        if (brg_expired && sda_s) st_d = ST_WAIT_HI;
      end
      ST_WAIT_HI: if (scl_s) begin
        if (!sda_s) bcol_evt = 1'b1;
        else begin
          st_d     = ST_BOTH_HI;
          brg_load = 1'b1;
        end
      end
      ST_BOTH_HI: begin
        brg_run = 1'b1;
        if (!scl_s) bcol_evt = 1'b1;
        else if (brg_expired) begin
          st_d     = ST_SDA_LO;
          brg_load = 1'b1;
        end
      end
      ST_SDA_LO: begin
        brg_run = 1'b1;
        if (brg_expired) begin
          st_d     = ST_IDLE;
          hold_d   = 1'b1;
          done_evt = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (bcol_evt) begin
      st_d   = ST_IDLE;
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign scl_oe    = (st_q == ST_PULL) || (st_q == ST_SDA_HI);
  assign sda_oe    = (st_q == ST_SDA_LO) || (st_q == ST_IDLE && hold_q);
  assign rs_req    = (st_q != ST_IDLE);
  assign start_evt = is_start(scl_prev, scl_s, sda_prev, sda_s);

  // R1: request refused while another event is pending
  a_r1_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_set && evt_pending) |=> !rs_req);
  // R2: no counter load until SCL is seen low
  a_r2_wait_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULL && scl_s) |=> (scl_oe && st_q == ST_PULL));
  // R3: SCL stays held while SDA is seen low
  a_r3_hold_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SDA_HI && !sda_s) |=> scl_oe);
  // R5: SDA left pulled low after completion
  a_r5_keep_sda: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (sda_oe && !rs_req && !scl_oe));
  // R9: collision releases both lines
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    bcol_evt |=> (!scl_oe && !sda_oe && !rs_req));
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen #(
  parameter int BRG_W       = 7,
  parameter int DATA_W      = 8,
  parameter int CTL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_req_set,
  input  logic [BRG_W-1:0]  brg_reload,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_data,
  input  logic              flags_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rs_req,
  output logic              start_seen,
  output logic              irq_flag,
  output logic              wcol,
  output logic              bcol,
  output logic [DATA_W-1:0] tx_buf,
  output logic [CTL_W-1:0]  ctl_bits
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s, line_p;
  logic brg_load, brg_run, brg_expired;
  logic done_evt, bcol_evt, start_evt;

  rs_line_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({scl_in, sda_in}),
    .sync_o(line_s), .prev_o(line_p)
  );

  rs_baud_ctr #(.W(BRG_W)) u_brg (
    .clk(clk), .rst_n(rst_n), .load(brg_load), .run(brg_run),
    .reload(brg_reload), .expired(brg_expired)
  );

  rs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_set(rs_req_set),
    .evt_pending(ctl_bits != '0),
    .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_prev(line_p[1]), .sda_prev(line_p[0]),
    .brg_expired(brg_expired), .brg_load(brg_load), .brg_run(brg_run),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rs_req(rs_req),
    .done_evt(done_evt), .bcol_evt(bcol_evt), .start_evt(start_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      irq_flag   <= 1'b0;
      wcol       <= 1'b0;
      bcol       <= 1'b0;
      tx_buf     <= '0;
      ctl_bits   <= '0;
    end else begin
      if (flags_clr) begin
        start_seen <= 1'b0;
        irq_flag   <= 1'b0;
        wcol       <= 1'b0;
        bcol       <= 1'b0;
      end
      if (start_evt) start_seen <= 1'b1;
      if (done_evt)  irq_flag   <= 1'b1;
      if (bcol_evt)  bcol       <= 1'b1;
      if (tx_wr) begin
        if (rs_req) wcol   <= 1'b1;
        else        tx_buf <= tx_data;
      end
      if (ctl_wr && !rs_req) ctl_bits <= ctl_data;
    end
  end

  // R7: buffer write during the sequence collides and is dropped
  a_r7_wcol: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && rs_req) |=> (wcol && $stable(tx_buf)));
  // R8: control writes refused during the sequence
  a_r8_no_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && rs_req) |=> $stable(ctl_bits));
  // R9: collision never raises the completion flag
  a_r9_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bcol_evt && !irq_flag) |=> !irq_flag);
endmodule

// File: tb/sim_i2c_rstart_gen.sv
module sim_i2c_rstart_gen;
  localparam int SYNC_LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rs_req_set = 0, tx_wr = 0, ctl_wr = 0, flags_clr = 0;
  logic [6:0] brg_reload = 7'd7;
  logic [7:0] tx_data = '0;
  logic [3:0] ctl_data = '0;
  logic scl_ext = 0, sda_ext = 0;
  logic scl_oe, sda_oe, rs_req, start_seen, irq_flag, wcol, bcol;
  logic [7:0] tx_buf;
  logic [3:0] ctl_bits;
  wire scl_line = ~(scl_oe | scl_ext);
  wire sda_line = ~(sda_oe | sda_ext);

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_rstart_gen u0 (
    .clk(clk), .rst_n(rst_n), .rs_req_set(rs_req_set), .brg_reload(brg_reload),
    .tx_wr(tx_wr), .tx_data(tx_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .flags_clr(flags_clr), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rs_req(rs_req), .start_seen(start_seen),
    .irq_flag(irq_flag), .wcol(wcol), .bcol(bcol), .tx_buf(tx_buf), .ctl_bits(ctl_bits)
  );

  function automatic int unit_len(input int r);
    int n = 0;
    for (int i = 0; i <= r; i++) n++;
    return n;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) rs_req_set = 1;
    @(negedge clk) rs_req_set = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flags_clr = 1;
    @(negedge clk) flags_clr = 0;
  endtask

  // Runs one sequence and measures phase lengths at the ports.
  task automatic run_seq(input int stretch, input int sda_hold,
                         output int n_scl, output int n_both, output int n_sda,
                         output int irq_at_s);
    int guard = 0;
    bit s_seen = 0;
    n_scl = 0; n_both = 0; n_sda = 0; irq_at_s = -1;
    if (stretch > 0) scl_ext = 1;
    if (sda_hold > 0) sda_ext = 1;
    pulse_req();
    while (rs_req && guard < 2000) begin
      guard++;
      if (scl_oe) n_scl++;
      if (!scl_oe && !sda_oe) n_both++;
      if (sda_oe) n_sda++;
      if (start_seen && !s_seen) begin s_seen = 1; irq_at_s = irq_flag; end
      if (sda_hold > 0 && n_scl == sda_hold) sda_ext = 0;
      if (stretch > 0 && n_both == stretch + 1) scl_ext = 0;
      @(negedge clk);
    end
    scl_ext = 0; sda_ext = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset rs_req", rs_req, 0);
    chk("R10 reset scl_oe", scl_oe, 0);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset flags", {start_seen, irq_flag, wcol, bcol}, 0);
    chk("R10 reset tx_buf", tx_buf, 0);
  endtask

  task automatic t_basic(input int r);
    int a, b, c, s;
    brg_reload = 7'(r);
    clear_flags();
    run_seq(0, 0, a, b, c, s);
    chk("R2 scl low length", a, unit_len(r) + SYNC_LAT + 1);
    chk("R4 both released length", b, unit_len(r) + SYNC_LAT + 1);
    chk("R5 sda low length", c, unit_len(r));
    chk("R6 irq clear when start seen", s, 0);
    chk("R6 irq set at end", irq_flag, 1);
    chk("R6 start_seen", start_seen, 1);
    chk("R5 sda kept low", sda_oe, 1);
    chk("R5 scl released", scl_oe, 0);
  endtask

  task automatic t_stretch();
    int a, b, c, s;
    brg_reload = 7'd7;
    clear_flags();
    run_seq(10, 0, a, b, c, s);
    chk("R4 stretched released length", b, unit_len(7) + SYNC_LAT + 1 + 10);
    chk("R4 completes after stretch", irq_flag, 1);
  endtask

  task automatic t_sda_hold();
    int a, b, c, s;
    brg_reload = 7'd7;
    clear_flags();
    run_seq(0, 20, a, b, c, s);
    chk("R3 scl held while sda low", a, 20 + SYNC_LAT);
    chk("R3 completes after hold", irq_flag, 1);
    chk("R3 no collision", bcol, 0);
  endtask

  task automatic wait_scl_release();
    int guard = 0;
    while (!(rs_req && !scl_oe) && guard < 500) begin guard++; @(negedge clk); end
  endtask

  task automatic t_bcol_sda();
    brg_reload = 7'd7;
    clear_flags();
    pulse_req();
    wait_scl_release();
    sda_ext = 1;
    repeat (5) @(negedge clk);
    chk("R9 bcol on sda low at scl rise", bcol, 1);
    chk("R9 rs_req cleared", rs_req, 0);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    chk("R9 no irq", irq_flag, 0);
    sda_ext = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_bcol_scl();
    brg_reload = 7'd7;
    clear_flags();
    pulse_req();
    wait_scl_release();
    repeat (4) @(negedge clk);
    chk("R9 still running before pull", {rs_req, bcol}, 2);
    scl_ext = 1;
    repeat (5) @(negedge clk);
    chk("R9 bcol on scl low in high phase", bcol, 1);
    chk("R9 lines released on scl collision", {scl_oe, sda_oe, rs_req}, 0);
    chk("R9 no irq on scl collision", irq_flag, 0);
    scl_ext = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_interlock();
    int guard = 0;
    brg_reload = 7'd7;
    clear_flags();
    @(negedge clk) begin tx_wr = 1; tx_data = 8'hA5; end
    @(negedge clk) tx_wr = 0;
    chk("R7 idle write loads", tx_buf, 8'hA5);
    chk("R7 idle write no wcol", wcol, 0);
    pulse_req();
    repeat (3) @(negedge clk);
    tx_wr = 1; tx_data = 8'h3C; ctl_wr = 1; ctl_data = 4'h5;
    @(negedge clk) begin tx_wr = 0; ctl_wr = 0; end
    chk("R7 busy write keeps buffer", tx_buf, 8'hA5);
    chk("R7 busy write sets wcol", wcol, 1);
    chk("R8 busy ctl write ignored", ctl_bits, 0);
    while (rs_req && guard < 500) begin guard++; @(negedge clk); end
    chk("R8 sequence completed", irq_flag, 1);
    @(negedge clk) begin ctl_wr = 1; ctl_data = 4'h3; end
    @(negedge clk) ctl_wr = 0;
    chk("R8 idle ctl write loads", ctl_bits, 3);
    pulse_req();
    @(negedge clk);
    chk("R1 request refused while pending", {rs_req, scl_oe}, 0);
    @(negedge clk) begin ctl_wr = 1; ctl_data = 4'h0; end
    @(negedge clk) ctl_wr = 0;
  endtask

  task automatic t_clear();
    clear_flags();
    chk("R10 flags cleared", {start_seen, irq_flag, wcol, bcol}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic(7);
    t_basic(3);
    t_stretch();
    t_sda_hold();
    t_bcol_sda();
    t_bcol_scl();
    t_interlock();
    t_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule